// File: doc/BRIEF.md
# Reorder-Buffer Head Retirement

This block sits at the back end of an out-of-order pipeline. Each cycle it looks at a window of the oldest reorder-buffer entries of the thread picked for commit. It walks that window in age order and decides, entry by entry, whether the entry leaves the buffer, whether the walk must stop, or whether a fault must start a trap. Squashed entries are dropped without using commit bandwidth.

Operations that must run alone are held back until the first commit slot of a cycle, and only when no store is still waiting for writeback. These are non-speculative instructions, store-conditionals, barriers, uncached loads and faulting instructions. Once released, they hand a request back to the execute stage or start the trap timer, and the walk stops.

For every instruction it commits, the block reports a write to the committed rename map. It also moves the architectural PC pair forward and records the done sequence number. It keeps the committed-instruction and full-width-cycle counts, and it tells earlier stages when the buffer has truly drained.

Top module: `rob_retire_top`

## Requirements
- R1: The head window `headBus` holds WIN records of 40 bits each. Slot i sits at bits [40i+39:40i], and slot 0 is the oldest. The fields of a record, from the MSB, are: valid, ready, squashed, executed, nonSpec, storeCond, barrier, isLoad, isStore, fault, nopPf, hasDest, destArch[4:0], destPhys[6:0], seq[15:0]. A valid squashed entry reached before the commit width is used up is removed: it counts in `popCount` but not in `commitCount`.
- R2: An unexecuted, ready head marked nonSpec, storeCond or barrier stops the walk. It raises `nonSpecReq` with `reqSeq` equal to its seq only if it is in commit slot 0 and `storesPending` is low. It is never removed.
- R3: An unexecuted, ready load head follows the same slot-0 and no-pending-store rule. When the rule is met it raises `uncachedReq` with its seq. It is never removed.
- R4: An executed head with fault set stops the walk. In slot 0 with no pending stores it raises `trapStart`. `trapPending` is then high for exactly TRAP_LAT cycles, and `trapSquash` is high in the last of those cycles. While `trapPending` is high, nothing is removed and no request is made.
- R5: The n-th instruction committed in a cycle (n from 0) drives `mapWe[n]`, together with its destArch and destPhys in lane n of `mapArch` and `mapPhys`, if its hasDest bit is set.
- R6: After a cycle that commits at least one instruction, `doneSeq` holds the seq of the last one committed. Otherwise `doneSeq` keeps its value.
- R7: Each committed instruction sets `pc` to the old `nextPc` and then advances `nextPc` by INST_BYTES.
- R8: `instCount` grows by the number of committed instructions whose nopPf bit is clear.
- R9: `emptyReport` is high in the cycle after a cycle in which three things all hold: no valid entry is left in the window after removal, `robMore` is low, and neither `storesPending` nor a committed store occurred.
- R10: The walk stops at the first entry that is invalid or not ready, or that stalls. `commitCount` never exceeds WIDTH, and no entry is looked at once WIDTH instructions have committed.
- R11: `fullWidthCount` increments in each cycle where `commitCount` equals WIDTH.
- R12: After reset, `pc` is RESET_PC, `nextPc` is RESET_PC+INST_BYTES, `doneSeq`, `instCount` and `fullWidthCount` are 0, `emptyReport` is 1 and `trapPending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| headBus | input | WIN*40 | Oldest reorder-buffer entries of the selected thread |
| robMore | input | 1 | Entries exist beyond the window |
| storesPending | input | 1 | Stores still await writeback |
| popCount | output | 4 | Entries removed this cycle |
| commitCount | output | 4 | Instructions committed this cycle |
| mapWe | output | WIDTH | Committed rename map write enables, one per lane |
| mapArch | output | WIDTH*5 | Architectural register per lane |
| mapPhys | output | WIDTH*7 | Physical register per lane |
| nonSpecReq | output | 1 | Request to execute the head non-speculatively |
| uncachedReq | output | 1 | Request to re-execute the head load as uncached |
| reqSeq | output | 16 | Sequence number carried by either request |
| trapStart | output | 1 | Faulting head starts a trap |
| trapPending | output | 1 | Trap latency window active |
| trapSquash | output | 1 | Last cycle of the trap window |
| doneSeq | output | 16 | Sequence number of the youngest committed instruction |
| pc | output | PC_W | Architectural PC |
| nextPc | output | PC_W | Architectural next PC |
| instCount | output | CNT_W | Committed instructions, nops and prefetches excluded |
| fullWidthCount | output | CNT_W | Cycles that used the full commit width |
| emptyReport | output | 1 | Buffer reported empty to earlier stages |

## Verification
The bench goes after these corner cases:
- A serializing or faulting head that sits behind a commit in the same cycle. A design that ignored the slot rule would issue its request or trap too early.
- A squashed entry that comes after the width is used up. A design that dropped it anyway would over-count `popCount`.
- A store committed in a cycle that otherwise drains the buffer. A design that missed this would report empty one cycle too early.
- The trap window. Its length is checked cycle by cycle, as is the rule that a full window of ready instructions stays untouched until `trapSquash`.
- Nop-only bursts. They must move the PC but leave `instCount` alone.

// File: rtl/rob_retire_pkg.sv
package rob_retire_pkg;
  localparam int ARCH_W = 5;
  localparam int PHYS_W = 7;
  localparam int SEQ_W  = 16;
  localparam int SLOT_W = 4;

  typedef struct packed {
    logic              valid;
    logic              ready;
    logic              squashed;
    logic              executed;
    logic              nonSpec;
    logic              storeCond;
    logic              barrier;
    logic              isLoad;
    logic              isStore;
    logic              fault;
    logic              nopPf;
    logic              hasDest;
    logic [ARCH_W-1:0] destArch;
    logic [PHYS_W-1:0] destPhys;
    logic [SEQ_W-1:0]  seq;
  } headEntry_t;

  localparam int ENTRY_W = $bits(headEntry_t);

  // strobes from the walk control to the architectural state datapath
  typedef struct packed {
    logic [SLOT_W-1:0] commitCnt;
    logic [SLOT_W-1:0] countedCnt;
    logic              seqWe;
    logic [SEQ_W-1:0]  lastSeq;
    logic              storeDone;
    logic              drained;
  } retireStrobe_t;
endpackage

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl
  import rob_retire_pkg::*;
#(
  parameter int WIN      = 6,
  parameter int WIDTH    = 3,
  parameter int TRAP_LAT = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [WIN*ENTRY_W-1:0]  headBus,
  input  logic                    robMore,
  input  logic                    storesPending,
  output logic [SLOT_W-1:0]       popCount,
  output logic [WIDTH-1:0]        mapWe,
  output logic [WIDTH*ARCH_W-1:0] mapArch,
  output logic [WIDTH*PHYS_W-1:0] mapPhys,
  output logic                    nonSpecReq,
  output logic                    uncachedReq,
  output logic [SEQ_W-1:0]        reqSeq,
  output logic                    trapStart,
  output logic                    trapPending,
  output logic                    trapSquash,
  output retireStrobe_t           strobe
);
  localparam int TW = $clog2(TRAP_LAT + 1);
  localparam logic [SLOT_W-1:0] WIDTH_S = SLOT_W'(WIDTH);

  headEntry_t ents [WIN];

  for (genvar g = 0; g < WIN; g++) begin : gUnpack
    assign ents[g] = headEntry_t'(headBus[g*ENTRY_W +: ENTRY_W]);
  end

  logic [TW-1:0] trapTimer;
  logic          trapActive;
  logic          trapGo;
  assign trapActive = (trapTimer != '0);

  logic              stop;
  logic [SLOT_W-1:0] nCommit;
  logic [SLOT_W-1:0] nPop;
  logic [SLOT_W-1:0] nCounted;
  logic [SEQ_W-1:0]  youngSeq;
  logic              storeSeen;
  logic              leftOver;

  always_comb begin
    stop        = 1'b0;
    nCommit     = '0;
    nPop        = '0;
    nCounted    = '0;
    youngSeq    = '0;
    storeSeen   = 1'b0;
    leftOver    = robMore;
    mapWe       = '0;
    mapArch     = '0;
    mapPhys     = '0;
    nonSpecReq  = 1'b0;
    uncachedReq = 1'b0;
    reqSeq      = '0;
    trapGo      = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      if (!stop) begin
        if (trapActive || !ents[i].valid) begin
          stop = 1'b1;
        end else if (nCommit == WIDTH_S) begin
          stop = 1'b1;
        end else if (ents[i].squashed) begin
          nPop = nPop + SLOT_W'(1);
        end else if (!ents[i].ready) begin
          stop = 1'b1;
        end else if (!ents[i].executed) begin
          stop = 1'b1;
          if (nCommit == '0 && !storesPending) begin
            if (ents[i].nonSpec || ents[i].storeCond || ents[i].barrier) begin
              nonSpecReq = 1'b1;
              reqSeq     = ents[i].seq;
            end else if (ents[i].isLoad) begin
              uncachedReq = 1'b1;
              reqSeq      = ents[i].seq;
            end
          end
        end else if (ents[i].fault) begin
          stop = 1'b1;
          if (nCommit == '0 && !storesPending) trapGo = 1'b1;
        end else begin
          mapWe[nCommit]                    = ents[i].hasDest;
          mapArch[nCommit*ARCH_W +: ARCH_W] = ents[i].destArch;
          mapPhys[nCommit*PHYS_W +: PHYS_W] = ents[i].destPhys;
          nCommit  = nCommit + SLOT_W'(1);
          nPop     = nPop + SLOT_W'(1);
          youngSeq = ents[i].seq;
          if (!ents[i].nopPf) nCounted = nCounted + SLOT_W'(1);
          if (ents[i].isStore) storeSeen = 1'b1;
        end
      end
    end
    for (int i = 0; i < WIN; i++) begin
      if (ents[i].valid && SLOT_W'(i) >= nPop) leftOver = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapTimer <= '0;
    end else if (trapActive) begin
      trapTimer <= trapTimer - TW'(1);
    end else if (trapGo) begin
      trapTimer <= TW'(TRAP_LAT);
    end
  end

  assign popCount    = nPop;
  assign trapStart   = trapGo;
  assign trapPending = trapActive;
  assign trapSquash  = (trapTimer == TW'(1));

  assign strobe.commitCnt  = nCommit;
  assign strobe.countedCnt = nCounted;
  assign strobe.seqWe      = (nCommit != '0);
  assign strobe.lastSeq    = youngSeq;
  assign strobe.storeDone  = storeSeen;
  assign strobe.drained    = !leftOver;
endmodule

// File: rtl/rob_retire_dp.sv
module rob_retire_dp
  import rob_retire_pkg::*;
#(
  parameter int               WIDTH      = 3,
  parameter int               PC_W       = 32,
  parameter int               CNT_W      = 32,
  parameter int               INST_BYTES = 4,
  parameter logic [PC_W-1:0]  RESET_PC   = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  retireStrobe_t     strobe,
  input  logic              storesPending,
  output logic [SEQ_W-1:0]  doneSeq,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   nextPc,
  output logic [CNT_W-1:0]  instCount,
  output logic [CNT_W-1:0]  fullWidthCount,
  output logic              emptyReport
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  logic [PC_W-1:0] stepAll;
  logic [PC_W-1:0] stepLess;
  assign stepAll  = PC_W'(int'(strobe.commitCnt) * INST_BYTES);
  assign stepLess = stepAll - STEP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc             <= RESET_PC;
      nextPc         <= RESET_PC + STEP;
      doneSeq        <= '0;
      instCount      <= '0;
      fullWidthCount <= '0;
      emptyReport    <= 1'b1;
    end else begin
      if (strobe.commitCnt != '0) begin
        pc     <= nextPc + stepLess;
        nextPc <= nextPc + stepAll;
      end
      if (strobe.seqWe) doneSeq <= strobe.lastSeq;
      instCount <= instCount + CNT_W'(strobe.countedCnt);
      if (strobe.commitCnt == SLOT_W'(WIDTH)) fullWidthCount <= fullWidthCount + CNT_W'(1);
      emptyReport <= strobe.drained && !storesPending && !strobe.storeDone;
    end
  end
endmodule

// File: rtl/rob_retire_top.sv
module rob_retire_top
  import rob_retire_pkg::*;
#(
  parameter int              WIN        = 6,
  parameter int              WIDTH      = 3,
  parameter int              TRAP_LAT   = 5,
  parameter int              PC_W       = 32,
  parameter int              CNT_W      = 32,
  parameter int              INST_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC   = 32'h0000_1000
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [WIN*ENTRY_W-1:0]  headBus,
  input  logic                    robMore,
  input  logic                    storesPending,
  output logic [SLOT_W-1:0]       popCount,
  output logic [SLOT_W-1:0]       commitCount,
  output logic [WIDTH-1:0]        mapWe,
  output logic [WIDTH*ARCH_W-1:0] mapArch,
  output logic [WIDTH*PHYS_W-1:0] mapPhys,
  output logic                    nonSpecReq,
  output logic                    uncachedReq,
  output logic [SEQ_W-1:0]        reqSeq,
  output logic                    trapStart,
  output logic                    trapPending,
  output logic                    trapSquash,
  output logic [SEQ_W-1:0]        doneSeq,
  output logic [PC_W-1:0]         pc,
  output logic [PC_W-1:0]         nextPc,
  output logic [CNT_W-1:0]        instCount,
  output logic [CNT_W-1:0]        fullWidthCount,
  output logic                    emptyReport
);
  retireStrobe_t strobe;

  rob_retire_ctrl #(.WIN(WIN), .WIDTH(WIDTH), .TRAP_LAT(TRAP_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .headBus(headBus), .robMore(robMore),
    .storesPending(storesPending), .popCount(popCount), .mapWe(mapWe),
    .mapArch(mapArch), .mapPhys(mapPhys), .nonSpecReq(nonSpecReq),
    .uncachedReq(uncachedReq), .reqSeq(reqSeq), .trapStart(trapStart),
    .trapPending(trapPending), .trapSquash(trapSquash), .strobe(strobe)
  );

  rob_retire_dp #(.WIDTH(WIDTH), .PC_W(PC_W), .CNT_W(CNT_W),
                  .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .storesPending(storesPending),
    .doneSeq(doneSeq), .pc(pc), .nextPc(nextPc), .instCount(instCount),
    .fullWidthCount(fullWidthCount), .emptyReport(emptyReport)
  );

  assign commitCount = strobe.commitCnt;
endmodule

// File: rtl/rob_retire_checker.sv
module rob_retire_checker
  import rob_retire_pkg::*;
#(
  parameter int WIDTH      = 3,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [SLOT_W-1:0] popCount,
  input logic [SLOT_W-1:0] commitCount,
  input logic              nonSpecReq,
  input logic              uncachedReq,
  input logic              trapStart,
  input logic              trapPending,
  input logic              storesPending,
  input logic [PC_W-1:0]   pc
);
  AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rstN)
    commitCount <= SLOT_W'(WIDTH)); // R10
  AST_POP_COVERS: assert property (@(posedge clk) disable iff (!rstN)
    popCount >= commitCount); // R1
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({nonSpecReq, uncachedReq, trapStart})); // R2
  AST_SERIAL_SLOT0: assert property (@(posedge clk) disable iff (!rstN)
    (nonSpecReq || uncachedReq || trapStart) |-> (commitCount == '0 && !storesPending)); // R3
  AST_TRAP_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    trapPending |-> (popCount == '0 && !trapStart)); // R4
  AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    trapStart |=> trapPending); // R4
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> pc == PC_W'($past(pc) + PC_W'(int'($past(commitCount)) * INST_BYTES))); // R7
endmodule

bind rob_retire_top rob_retire_checker #(.WIDTH(WIDTH), .PC_W(PC_W), .INST_BYTES(INST_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .popCount(popCount), .commitCount(commitCount),
  .nonSpecReq(nonSpecReq), .uncachedReq(uncachedReq), .trapStart(trapStart),
  .trapPending(trapPending), .storesPending(storesPending), .pc(pc)
);

// File: tb/rob_retire_top_tb.sv
module rob_retire_top_tb;
  import rob_retire_pkg::*;

  localparam int WIN = 6, WIDTH = 3, TRAP_LAT = 5, PC_W = 32, CNT_W = 32, IB = 4;
  localparam logic [PC_W-1:0] RPC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [WIN*ENTRY_W-1:0] headBus = '0;
  logic robMore = 1'b0, storesPending = 1'b0;
  logic [SLOT_W-1:0] popCount, commitCount;
  logic [WIDTH-1:0] mapWe;
  logic [WIDTH*ARCH_W-1:0] mapArch;
  logic [WIDTH*PHYS_W-1:0] mapPhys;
  logic nonSpecReq, uncachedReq, trapStart, trapPending, trapSquash, emptyReport;
  logic [SEQ_W-1:0] reqSeq, doneSeq;
  logic [PC_W-1:0] pc, nextPc;
  logic [CNT_W-1:0] instCount, fullWidthCount;

  always #2 clk = ~clk;

  rob_retire_top #(.WIN(WIN), .WIDTH(WIDTH), .TRAP_LAT(TRAP_LAT), .PC_W(PC_W),
                   .CNT_W(CNT_W), .INST_BYTES(IB), .RESET_PC(RPC)) u_dut (
    .clk(clk), .rstN(rstN), .headBus(headBus), .robMore(robMore),
    .storesPending(storesPending), .popCount(popCount), .commitCount(commitCount),
    .mapWe(mapWe), .mapArch(mapArch), .mapPhys(mapPhys), .nonSpecReq(nonSpecReq),
    .uncachedReq(uncachedReq), .reqSeq(reqSeq), .trapStart(trapStart),
    .trapPending(trapPending), .trapSquash(trapSquash), .doneSeq(doneSeq), .pc(pc),
    .nextPc(nextPc), .instCount(instCount), .fullWidthCount(fullWidthCount),
    .emptyReport(emptyReport)
  );

  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;
  headEntry_t win [WIN];
  int seqCtr = 1;

  // model state
  longint mPc, mNpc, mDone, mInst, mFull;
  bit mEmpty;
  int mTimer;
  // model results for one cycle
  int eK, ePop, eCounted;
  bit eNs, eUc, eTrap, eStore, eLeft;
  longint eSeq, eLast;
  bit eWe [WIDTH];
  longint eArch [WIDTH], ePhys [WIDTH];

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic headEntry_t mk(input int kind, input int sq);
    headEntry_t e;
    e = '0;
    e.valid = 1'b1; e.ready = 1'b1; e.executed = 1'b1; e.hasDest = 1'b1;
    e.destArch = ARCH_W'(sq % 31 + 1);
    e.destPhys = PHYS_W'((sq * 3) % 128);
    e.seq = SEQ_W'(sq);
    case (kind)
      1: e.squashed = 1'b1;
      2: begin e.executed = 1'b0; e.nonSpec = 1'b1; end
      3: begin e.executed = 1'b0; e.isLoad = 1'b1; end
      4: e.fault = 1'b1;
      5: begin e.nopPf = 1'b1; e.hasDest = 1'b0; end
      6: begin e.isStore = 1'b1; e.hasDest = 1'b0; end
      7: e.ready = 1'b0;
      8: begin e.executed = 1'b0; e.storeCond = 1'b1; end
      9: begin e.executed = 1'b0; e.barrier = 1'b1; end
      default: ;
    endcase
    return e;
  endfunction

  function automatic int pickKind();
    int r;
    r = int'($urandom_range(0, 99));
    if (r < 50) return 0;
    if (r < 62) return 1;
    if (r < 66) return 2;
    if (r < 70) return 3;
    if (r < 75) return 4;
    if (r < 82) return 5;
    if (r < 90) return 6;
    if (r < 95) return 7;
    if (r < 97) return 8;
    return 9;
  endfunction

  task automatic fill(input int k0, input int k1, input int k2, input int k3,
                      input int k4, input int k5);
    int ks [6];
    ks = '{k0, k1, k2, k3, k4, k5};
    for (int i = 0; i < WIN; i++) begin
      if (ks[i] < 0) win[i] = '0;
      else begin win[i] = mk(ks[i], seqCtr); seqCtr++; end
    end
  endtask

  task automatic modelEval();
    bit stop;
    stop = 0; eK = 0; ePop = 0; eCounted = 0; eNs = 0; eUc = 0; eTrap = 0;
    eStore = 0; eSeq = 0; eLast = 0; eLeft = robMore;
    for (int w = 0; w < WIDTH; w++) begin eWe[w] = 0; eArch[w] = 0; ePhys[w] = 0; end
    for (int i = 0; i < WIN; i++) begin
      if (!stop) begin
        if (mTimer != 0 || !win[i].valid) stop = 1;
        else if (eK == WIDTH) stop = 1;
        else if (win[i].squashed) ePop++;
        else if (!win[i].ready) stop = 1;
        else if (!win[i].executed) begin
          stop = 1;
          if (eK == 0 && !storesPending) begin
            if (win[i].nonSpec || win[i].storeCond || win[i].barrier) begin eNs = 1; eSeq = win[i].seq; end
            else if (win[i].isLoad) begin eUc = 1; eSeq = win[i].seq; end
          end
        end else if (win[i].fault) begin
          stop = 1;
          if (eK == 0 && !storesPending) eTrap = 1;
        end else begin
          eWe[eK] = win[i].hasDest; eArch[eK] = win[i].destArch; ePhys[eK] = win[i].destPhys;
          eK++; ePop++; eLast = win[i].seq;
          if (!win[i].nopPf) eCounted++;
          if (win[i].isStore) eStore = 1;
        end
      end
    end
    for (int i = 0; i < WIN; i++) if (win[i].valid && i >= ePop) eLeft = 1;
  endtask

  task automatic runCycle();
    @(negedge clk);
    for (int i = 0; i < WIN; i++) headBus[i*ENTRY_W +: ENTRY_W] = win[i];
    #1;
    modelEval();
    chk("R1 popCount", popCount, ePop);
    chk("R10 commitCount", commitCount, eK);
    chk("R2 nonSpecReq", nonSpecReq, eNs);
    chk("R3 uncachedReq", uncachedReq, eUc);
    if (eNs || eUc) chk("R2 R3 reqSeq", reqSeq, eSeq);
    chk("R4 trapStart", trapStart, eTrap);
    chk("R4 trapPending", trapPending, mTimer != 0);
    chk("R4 trapSquash", trapSquash, mTimer == 1);
    for (int w = 0; w < WIDTH; w++) begin
      chk("R5 mapWe", mapWe[w], eWe[w]);
      if (eWe[w]) begin
        chk("R5 mapArch", mapArch[w*ARCH_W +: ARCH_W], eArch[w]);
        chk("R5 mapPhys", mapPhys[w*PHYS_W +: PHYS_W], ePhys[w]);
      end
    end
    @(posedge clk);
    if (mTimer != 0) mTimer--;
    else if (eTrap) mTimer = TRAP_LAT;
    if (eK > 0) begin
      mPc = (mNpc + (eK - 1) * IB) & 64'hFFFF_FFFF;
      mNpc = (mNpc + eK * IB) & 64'hFFFF_FFFF;
      mDone = eLast;
      if (eK == WIDTH) mFull++;
    end
    mInst += eCounted;
    mEmpty = !eLeft && !storesPending && !eStore;
    #1;
    chk("R7 pc", pc, mPc);
    chk("R7 nextPc", nextPc, mNpc);
    chk("R6 doneSeq", doneSeq, mDone);
    chk("R8 instCount", instCount, mInst);
    chk("R11 fullWidthCount", fullWidthCount, mFull);
    chk("R9 emptyReport", emptyReport, mEmpty);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < WIN; i++) win[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R12 reset state
    chk("R12 pc", pc, RPC);
    chk("R12 nextPc", nextPc, RPC + IB);
    chk("R12 doneSeq", doneSeq, 0);
    chk("R12 instCount", instCount, 0);
    chk("R12 fullWidthCount", fullWidthCount, 0);
    chk("R12 emptyReport", emptyReport, 1);
    chk("R12 trapPending", trapPending, 0);
    mPc = RPC; mNpc = RPC + IB; mDone = 0; mInst = 0; mFull = 0; mEmpty = 1; mTimer = 0;

    // R1: all-squashed window is removed free
    fill(1, 1, 1, 1, 1, 1); runCycle();
    // R10 R11: full width, then the rest waits
    fill(0, 0, 1, 0, 0, 0); runCycle();
    // R1: squashed entry after width reached stays
    fill(0, 0, 0, 1, -1, -1); runCycle();
    // R2: nonspec behind a commit stalls without request
    fill(0, 2, 0, -1, -1, -1); runCycle();
    // R2: nonspec in slot 0 with stores pending waits
    storesPending = 1'b1; fill(2, 0, -1, -1, -1, -1); runCycle();
    storesPending = 1'b0;
    // R2: slot 0, no pending stores, store-conditional and barrier
    fill(1, 8, -1, -1, -1, -1); runCycle();
    fill(9, -1, -1, -1, -1, -1); runCycle();
    // R3: uncached load
    fill(3, 0, -1, -1, -1, -1); runCycle();
    // R8: nops move the PC but are not counted
    fill(5, 5, 5, -1, -1, -1); runCycle();
    // R9: a committed store blocks the empty report
    fill(6, -1, -1, -1, -1, -1); runCycle();
    fill(-1, -1, -1, -1, -1, -1); runCycle();
    // R10: not-ready head stops the walk
    fill(7, 0, 0, -1, -1, -1); runCycle();
    // R4: fault behind a commit waits, then traps in slot 0
    fill(0, 4, -1, -1, -1, -1); runCycle();
    fill(4, 0, -1, -1, -1, -1); runCycle();
    for (int c = 0; c < TRAP_LAT + 1; c++) begin
      fill(0, 0, 0, 0, -1, -1); runCycle();
    end

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int len;
      len = int'($urandom_range(0, WIN));
      for (int i = 0; i < WIN; i++) begin
        if (i < len) begin win[i] = mk(pickKind(), seqCtr); seqCtr++; end
        else win[i] = '0;
      end
      robMore = ($urandom_range(0, 3) == 0);
      storesPending = ($urandom_range(0, 4) == 0);
      runCycle();
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule